// File: doc/BRIEF.md
# Test Vector Pattern Sequencer

This block plays a stored test program into a bank of tester pin channels, one vector per tester period. Each entry in its vector memory carries a sequencing opcode, a repeat count, drive values for the device inputs, compare codes for the device outputs, and an optional switch of the active timing (waveform) set. A plain step entry is presented once. A counted repeat holds the same vector for several consecutive periods.

The pin channels report a per-pin mismatch bit for the vector currently presented. The sequencer masks those bits with the vector's compare enables and keeps a sticky fail flag and the memory index of the first failing vector. When the last vector has been played it pulses done, and the fail flag is the run's result code: 0 means every compared output matched and 1 means at least one did not.

The program is written through a simple load port while the sequencer is idle. A run is launched with a start pulse that gives the index of the last entry to play.

Top module: `tvs_seq`

## Requirements
- R1: While reset is held and after its release, vec_vld, done, busy and fail_seen are 0.
- R2: A start pulse seen while idle launches a run. In the next cycle vec_vld is 1 and vec_idx is 0, and the run plays entries 0 to last_idx in order. A start pulse during a run is ignored.
- R3: An entry whose opcode bit (bit 24, the MSB of the default 25-bit entry) is 0 is presented for exactly one cycle, and the sequencer then advances to the next index.
- R4: An entry whose opcode bit is 1 is presented for N consecutive cycles, where N is its 9-bit count field (bits 23:15). A count of 0 plays once. Counts up to 511 are supported, including 363.
- R5: Bit 14 requests a waveform-set switch and bits 13:12 give the new set. The switch applies to the vector that carries it and stays in force for all later vectors until another switch occurs.
- R6: Bits 11:4 hold one 2-bit compare code per output pin, with pin k at bits 5+2k:4+2k. In each code the high bit enables compare and the low bit is the expected level, so 11 means expect high, 10 means expect low and 0x means no compare. Bits 3:0 are the drive values. All of these appear on vec_drv, vec_lvl and vec_cmp while the entry is presented.
- R7: fail_seen becomes 1 when a presented vector has a mismatch on a pin whose compare is enabled. Mismatches on pins that are not compared are ignored. fail_seen then stays 1 to the end of the run and is the result code at done (0 means pass, 1 means fail).
- R8: fail_at holds the index of the first failing vector. Later failures do not change it.
- R9: done is a one-cycle pulse in the cycle right after the last vector's final period, with vec_vld at 0.
- R10: Launching a run clears fail_seen and resets the waveform set to 0.
- R11: Load-port writes take effect while idle and are ignored while a run is in progress.
- R12: pin_mis is ignored while no vector is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tester period per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Vector memory write enable |
| ld_addr | input | 5 | Vector memory write index |
| ld_data | input | 25 | Vector entry to write |
| start | input | 1 | Run launch pulse |
| last_idx | input | 5 | Index of the last entry of the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | End-of-run pulse |
| vec_vld | output | 1 | A vector is presented this cycle |
| vec_idx | output | 5 | Index of the presented vector |
| vec_drv | output | 4 | Drive values for the input pins |
| vec_lvl | output | 4 | Expected output levels |
| vec_cmp | output | 4 | Per-pin compare enables |
| vec_wset | output | 2 | Active waveform set |
| pin_mis | input | 4 | Per-pin mismatch from the pin channels |
| fail_seen | output | 1 | Sticky fail flag and result code |
| fail_at | output | 5 | Index of the first failing vector |

## Verification
The hard case is when the end of a run and a compare failure fall in the same cycle. The last entry of the failing program has a compared mismatch in its only period, and that period is also the one in which the sequencer decides to stop. The bench expects done in the very next cycle, with fail_seen already at 1 and fail_at still holding the earlier first failure. A second collision puts a start pulse and a load-port write in the middle of a 363-period repeat. A scoreboard checks every period's vector against the expanded program, and a rerun of that program confirms that the write had no effect.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } seq_st_e;

   localparam logic OP_STEP = 1'b0;
   localparam logic OP_RPT  = 1'b1;
endpackage

// File: rtl/tvs_vmem.sv
module tvs_vmem #(
   parameter int EW    = 25,
   parameter int DEPTH = 32,
   parameter int AW    = 5
) (
   input  logic          clk,
   input  logic          lock,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [EW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [EW-1:0] rdata
);
   logic [EW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && !lock && (int'(waddr) < DEPTH))
         mem[waddr] <= wdata;
   end

   assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
endmodule

// File: rtl/tvs_step.sv
module tvs_step
   import tvs_pkg::*;
#(
   parameter int AW    = 5,
   parameter int CNT_W = 9,
   parameter int WS_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    last_idx,
   input  logic             op,
   input  logic [CNT_W-1:0] cnt,
   input  logic             chg,
   input  logic [WS_W-1:0]  set_new,
   output logic [AW-1:0]    addr,
   output logic             vld,
   output logic             busy,
   output logic             done,
   output logic             clr,
   output logic [WS_W-1:0]  wset
);
   seq_st_e          st_q;
   logic [AW-1:0]    addr_q, last_q;
   logic [CNT_W-1:0] rpt_q, n_eff;
   logic [WS_W-1:0]  wset_q;
   logic             last_rep;

   always_comb begin
      n_eff    = (op == OP_RPT && cnt != '0) ? cnt : CNT_W'(1);
      last_rep = (rpt_q == n_eff - CNT_W'(1));
      wset     = chg ? set_new : wset_q;
   end

   assign vld  = (st_q == ST_RUN);
   assign done = (st_q == ST_FIN);
   assign busy = (st_q != ST_IDLE);
   assign clr  = (st_q == ST_IDLE) && start;
   assign addr = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         last_q <= '0;
         rpt_q  <= '0;
         wset_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start) begin
               st_q   <= ST_RUN;
               addr_q <= '0;
               rpt_q  <= '0;
               wset_q <= '0;
               last_q <= last_idx;
            end
            ST_RUN: begin
               wset_q <= wset;
               if (last_rep) begin
                  rpt_q <= '0;
                  if (addr_q == last_q) st_q <= ST_FIN;
                  else                  addr_q <= addr_q + AW'(1);
               end else begin
                  rpt_q <= rpt_q + CNT_W'(1);
               end
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && $past(vld)) |-> (addr == $past(addr) || addr == $past(addr) + AW'(1)));
   p_rpt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !last_rep) |=> (vld && addr == $past(addr)));
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !vld);
   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (vld && addr == '0));
endmodule

// File: rtl/tvs_judge.sv
module tvs_judge #(
   parameter int NOUT = 4,
   parameter int AW   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            vld,
   input  logic [AW-1:0]   idx,
   input  logic [NOUT-1:0] cmp,
   input  logic [NOUT-1:0] mis,
   output logic            fail_seen,
   output logic [AW-1:0]   fail_at
);
   logic [NOUT-1:0] hit;
   logic            vec_bad;

   for (genvar k = 0; k < NOUT; k++) begin : g_pin
      assign hit[k] = cmp[k] & mis[k];
   end

   assign vec_bad = vld && (|hit);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         fail_seen <= 1'b0;
         fail_at   <= '0;
      end else if (vec_bad && !fail_seen) begin
         fail_seen <= 1'b1;
         fail_at   <= idx;
      end
   end

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_seen && !clr) |=> fail_seen);
   p_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_seen && !clr) |=> $stable(fail_at));
   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!vld && !clr) |=> $stable(fail_seen));
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !fail_seen);
endmodule

// File: rtl/tvs_seq.sv
module tvs_seq #(
   parameter int NIN    = 4,
   parameter int NOUT   = 4,
   parameter int CNT_W  = 9,
   parameter int DEPTH  = 32,
   parameter int N_SETS = 4,
   localparam int AW    = $clog2(DEPTH),
   localparam int WS_W  = $clog2(N_SETS),
   localparam int EW    = 1 + CNT_W + 1 + WS_W + 2*NOUT + NIN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_we,
   input  logic [AW-1:0]    ld_addr,
   input  logic [EW-1:0]    ld_data,
   input  logic             start,
   input  logic [AW-1:0]    last_idx,
   output logic             busy,
   output logic             done,
   output logic             vec_vld,
   output logic [AW-1:0]    vec_idx,
   output logic [NIN-1:0]   vec_drv,
   output logic [NOUT-1:0]  vec_lvl,
   output logic [NOUT-1:0]  vec_cmp,
   output logic [WS_W-1:0]  vec_wset,
   input  logic [NOUT-1:0]  pin_mis,
   output logic             fail_seen,
   output logic [AW-1:0]    fail_at
);
   localparam int O_EXP = NIN;
   localparam int O_SET = O_EXP + 2*NOUT;
   localparam int O_CHG = O_SET + WS_W;
   localparam int O_CNT = O_CHG + 1;
   localparam int O_OP  = O_CNT + CNT_W;

   if (CNT_W < 9) begin : g_chk_cnt
      $error("tvs_seq: CNT_W must hold a count of 363");
   end
   if (N_SETS < 2 || (1 << WS_W) != N_SETS) begin : g_chk_sets
      $error("tvs_seq: N_SETS must be a power of two, at least 2");
   end
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_chk_depth
      $error("tvs_seq: DEPTH must be a power of two, at least 2");
   end
   if (NIN < 1 || NOUT < 1) begin : g_chk_pins
      $error("tvs_seq: pin counts must be positive");
   end

   logic [EW-1:0]    ent;
   logic [AW-1:0]    addr;
   logic             clr;
   logic             run_vld;

   tvs_vmem #(.EW(EW), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk   (clk),
      .lock  (busy),
      .we    (ld_we),
      .waddr (ld_addr),
      .wdata (ld_data),
      .raddr (addr),
      .rdata (ent)
   );

   tvs_step #(.AW(AW), .CNT_W(CNT_W), .WS_W(WS_W)) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .last_idx (last_idx),
      .op       (ent[O_OP]),
      .cnt      (ent[O_CNT +: CNT_W]),
      .chg      (ent[O_CHG]),
      .set_new  (ent[O_SET +: WS_W]),
      .addr     (addr),
      .vld      (run_vld),
      .busy     (busy),
      .done     (done),
      .clr      (clr),
      .wset     (vec_wset)
   );

   for (genvar k = 0; k < NOUT; k++) begin : g_code
      assign vec_lvl[k] = ent[O_EXP + 2*k];
      assign vec_cmp[k] = run_vld & ent[O_EXP + 2*k + 1];
   end

   assign vec_drv = ent[NIN-1:0];
   assign vec_vld = run_vld;
   assign vec_idx = addr;

   tvs_judge #(.NOUT(NOUT), .AW(AW)) u_judge (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .vld       (run_vld),
      .idx       (addr),
      .cmp       (vec_cmp),
      .mis       (pin_mis),
      .fail_seen (fail_seen),
      .fail_at   (fail_at)
   );

   p_wset_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_vld && $past(vec_vld) && !ent[O_CHG]) |-> (vec_wset == $past(vec_wset)));
   p_wset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ent[O_CHG]) |=> (vec_wset == '0 || ent[O_CHG]));
   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (!vec_vld && !done && !fail_seen));
endmodule

// File: tb/tvs_seq_test.sv
module tvs_seq_test;
   localparam int CLK_NS = 10;
   localparam int NIN = 4, NOUT = 4, CNT_W = 9, AW = 5, WS_W = 2;
   localparam int EW = 1 + CNT_W + 1 + WS_W + 2*NOUT + NIN;

   typedef struct packed {
      logic [AW-1:0]   idx;
      logic [NIN-1:0]  drv;
      logic [NOUT-1:0] lvl;
      logic [NOUT-1:0] cmp;
      logic [WS_W-1:0] ws;
   } item_t;

   logic clk = 0, rst_n = 0;
   logic ld_we = 0, start = 0;
   logic [AW-1:0] ld_addr = '0, last_idx = '0;
   logic [EW-1:0] ld_data = '0;
   logic busy, done, vec_vld, fail_seen;
   logic [AW-1:0] vec_idx, fail_at;
   logic [NIN-1:0] vec_drv;
   logic [NOUT-1:0] vec_lvl, vec_cmp, pin_mis = '0;
   logic [WS_W-1:0] vec_wset;

   int errors = 0, checks = 0, done_cnt = 0;
   logic force_mis = 0, want_done = 0, prev_done = 0;
   logic exp_fail; logic [AW-1:0] exp_at;
   item_t q[$];

   logic            p_op [8];
   logic [CNT_W-1:0] p_cnt [8];
   logic            p_chg [8];
   logic [WS_W-1:0] p_set [8];
   logic [NIN-1:0]  p_drv [8];
   logic [2*NOUT-1:0] p_exp [8];
   logic [NOUT-1:0] mis_tab [32];
   int nent;

   tvs_seq uut (.*);

   always #(CLK_NS/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   always @(negedge clk)
      pin_mis <= force_mis ? '1 : (vec_vld ? mis_tab[vec_idx] : '0);

   // monitor: pops the scoreboard while vectors are presented
   always @(negedge clk) begin
      if (rst_n) begin
         if (want_done) begin
            chk(done === 1'b1, "R9", "done one cycle after last vector", done, 1);
            want_done = 0;
         end
         if (prev_done) chk(done === 1'b0, "R9", "done width", done, 0);
         if (vec_vld) begin
            if (q.size() == 0) chk(0, "R3", "unexpected vector", vec_idx, 0);
            else begin
               item_t e, a;
               e = q.pop_front();
               a = '{vec_idx, vec_drv, vec_lvl, vec_cmp, vec_wset};
               chk(a.idx === e.idx, "R4", "vector index", a.idx, e.idx);
               chk({a.drv, a.lvl, a.cmp} === {e.drv, e.lvl, e.cmp}, "R6",
                   "drive/level/compare", {a.drv, a.lvl, a.cmp}, {e.drv, e.lvl, e.cmp});
               chk(a.ws === e.ws, "R5", "waveform set", a.ws, e.ws);
               if (q.size() == 0) want_done = 1;
            end
         end
         if (done) begin
            chk(vec_vld === 1'b0 && q.size() == 0, "R9", "done with vectors pending",
                q.size(), 0);
            chk(fail_seen === exp_fail, "R7", "result code", fail_seen, exp_fail);
            if (exp_fail) chk(fail_at === exp_at, "R8", "first fail index", fail_at, exp_at);
            done_cnt++;
         end
         prev_done = done;
      end
   end

   function automatic logic [EW-1:0] pack(int i);
      return {p_op[i], p_cnt[i], p_chg[i], p_set[i], p_exp[i], p_drv[i]};
   endfunction

   task automatic ent(int i, logic op, int cnt, logic chg, int st,
                      logic [NIN-1:0] drv, logic [2*NOUT-1:0] ex, logic [NOUT-1:0] mis);
      p_op[i] = op; p_cnt[i] = CNT_W'(cnt); p_chg[i] = chg; p_set[i] = WS_W'(st);
      p_drv[i] = drv; p_exp[i] = ex; mis_tab[i] = mis;
   endtask

   task automatic load();
      for (int i = 0; i < nent; i++) begin
         @(negedge clk); ld_we = 1; ld_addr = AW'(i); ld_data = pack(i);
      end
      @(negedge clk); ld_we = 0;
   endtask

   // driver: expands the program into the expected per-period stream
   task automatic expand();
      logic [WS_W-1:0] cur = '0;
      exp_fail = 0; exp_at = '0;
      for (int i = 0; i < nent; i++) begin
         int n;
         logic [NOUT-1:0] lv, ce;
         n = (p_op[i] && p_cnt[i] != 0) ? int'(p_cnt[i]) : 1;
         if (p_chg[i]) cur = p_set[i];
         for (int k = 0; k < NOUT; k++) begin
            lv[k] = p_exp[i][2*k];
            ce[k] = p_exp[i][2*k+1];
         end
         if (!exp_fail && (ce & mis_tab[i]) != 0) begin exp_fail = 1; exp_at = AW'(i); end
         for (int r = 0; r < n; r++) q.push_back('{AW'(i), p_drv[i], lv, ce, cur});
      end
   endtask

   task automatic run(bit disturb);
      int d0 = done_cnt;
      expand();
      @(negedge clk); last_idx = AW'(nent - 1); start = 1;
      @(negedge clk); start = 0;
      chk(vec_vld === 1'b1 && vec_idx === '0, "R2", "run launch", vec_idx, 0);
      chk(fail_seen === 1'b0, "R10", "fail cleared at launch", fail_seen, 0);
      if (disturb) begin
         repeat (20) @(negedge clk);
         start = 1; ld_we = 1; ld_addr = '0; ld_data = '1;
         @(negedge clk); start = 0; ld_we = 0;
      end
      while (done_cnt == d0) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) mis_tab[i] = '0;
      repeat (3) @(negedge clk);
      chk(!vec_vld && !done && !busy && !fail_seen, "R1", "reset state",
          {vec_vld, done, busy, fail_seen}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!vec_vld && !done && !busy && !fail_seen, "R1", "after reset",
          {vec_vld, done, busy, fail_seen}, 0);

      // program A: steps, repeat 3, masked mismatches, set switches
      nent = 5;
      ent(0, 0, 0, 0, 0, 4'b1010, 8'b10_10_10_10, 4'b0000);
      ent(1, 1, 3, 0, 0, 4'b0101, 8'b11_10_00_11, 4'b0010); // R6 X pin masked
      ent(2, 0, 0, 1, 2, 4'b1100, 8'b00_00_00_00, 4'b1111); // R5 switch to 2
      ent(3, 1, 0, 0, 0, 4'b0011, 8'b10_11_10_11, 4'b0000); // R4 count 0 plays once
      ent(4, 0, 0, 1, 1, 4'b1001, 8'b11_11_11_11, 4'b0000);
      load();
      run(0);
      // R12: idle mismatches have no effect
      force_mis = 1;
      repeat (5) @(negedge clk);
      chk(fail_seen === 1'b0, "R12", "idle mismatch ignored", fail_seen, 0);
      force_mis = 0;

      // program B: repeat 363, compared failures, last vector fails at run end
      nent = 6;
      ent(0, 0, 0, 0, 0, 4'b0001, 8'b10_10_10_10, 4'b0000); // R10 set back to 0
      ent(1, 1, 363, 0, 0, 4'b0110, 8'b00_10_11_00, 4'b1001);
      ent(2, 0, 0, 1, 3, 4'b1110, 8'b10_10_10_10, 4'b0000);
      ent(3, 0, 0, 0, 0, 4'b0111, 8'b00_00_00_11, 4'b0001); // R7 first fail
      ent(4, 1, 2, 0, 0, 4'b1111, 8'b10_10_10_10, 4'b0000);
      ent(5, 0, 0, 0, 0, 4'b1000, 8'b10_11_10_10, 4'b0100); // R8 later fail
      load();
      run(1);  // R2/R11: start pulse and write mid-run are ignored
      @(negedge clk);
      chk(fail_seen === 1'b1, "R7", "result held after done", fail_seen, 1);
      run(0);  // same expectations prove entry 0 was not overwritten (R11)

      // reload program A while idle: load works, fail cleared (R10, R11)
      nent = 5;
      ent(0, 0, 0, 0, 0, 4'b1010, 8'b10_10_10_10, 4'b0000);
      ent(1, 1, 3, 0, 0, 4'b0101, 8'b11_10_00_11, 4'b0010);
      ent(2, 0, 0, 1, 2, 4'b1100, 8'b00_00_00_00, 4'b1111);
      ent(3, 1, 0, 0, 0, 4'b0011, 8'b10_11_10_11, 4'b0000);
      ent(4, 0, 0, 1, 1, 4'b1001, 8'b11_11_11_11, 4'b0000);
      load();
      run(0);
      repeat (3) @(negedge clk);
      chk(q.size() == 0 && !busy, "R9", "idle after runs", busy, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule